// File: doc/BRIEF.md
# I2C Master Serial-Clock Generator

This block produces the serial clock of an I2C master. It first divides the input clock by a programmable prescale value to form an internal module-clock enable. It then counts module-clock periods to shape the low and high halves of SCL. Each half has its own divide value, so the duty cycle can be set freely. The prescale value is captured only while the block is disabled. A new value therefore takes effect at the moment the block is enabled again.

SCL is open-drain. The block either pulls the line low or releases it, and never drives it high. The bus line is read back through a two-stage synchroniser. Because the line is a wired-AND of every device on it, the high-phase count does not start until the synchronised line is actually seen high. Any device that is still holding the clock low therefore stretches the high phase.

A one-cycle tick marks the start of every low phase for the bit engine. A flag warns when the latched prescale value places the module clock outside the allowed band for the configured input frequency.

Top module: `i2c_sclgen`

## Requirements
- R1: While reset is asserted and in the first cycles after it, `scl_oe` is 0 (line released) and `bit_tick` is 0. `scl_oe` = 1 means the block pulls SCL low. The block has no way to drive SCL high.
- R2: With latched prescale value P and low count L, every low phase keeps `scl_oe` at 1 for exactly (L+5)·(P+1) input-clock cycles.
- R3: `psc_val` is latched only while `mod_en` is 0. A change to `psc_val` while `mod_en` is 1 has no effect on phase lengths or on `psc_bad` until the block is next disabled.
- R4: With high count H, P ≥ 2 and no other device holding SCL low, every high phase keeps `scl_oe` at 0 for exactly (H+5)·(P+1) input-clock cycles.
- R5: `psc_bad` is 1 exactly when CLK_HZ/(P+1) is below MIN_HZ or above MAX_HZ, for the latched P. With the defaults of 100 MHz, 6.7 MHz and 13.3 MHz, P = 7 to 13 gives 0, and P ≤ 6 or P ≥ 14 gives 1. The flag follows `psc_val` within two cycles while the block is disabled.
- R6: The high-phase count advances only while the synchronised `scl_in` is 1. If another device holds SCL low after release, `scl_oe` stays 0 for the whole hold. After the line rises, the next pull-low comes between (H+4)·(P+1)+3 and (H+4)·(P+1)+P+3 input-clock edges later.
- R7: `bit_tick` is high for exactly one cycle. It is high in the first cycle of every low phase, and only then.
- R8: When `mod_en` is 0, `scl_oe` and `bit_tick` are 0 from the next clock edge on, and the counters are cleared. On the first edge that samples `mod_en` = 1, a low phase begins, with `scl_oe` = 1 and `bit_tick` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mod_en | input | 1 | 1 = block running; 0 = held in reset, prescale captured |
| psc_val | input | PSC_W | Prescale value P; module clock = clk/(P+1) |
| low_cnt | input | CNT_W | Low-phase divide value L |
| high_cnt | input | CNT_W | High-phase divide value H |
| scl_in | input | 1 | Sampled SCL bus line |
| scl_oe | output | 1 | 1 = pull SCL low, 0 = release |
| bit_tick | output | 1 | One-cycle pulse at the start of each low phase |
| psc_bad | output | 1 | Latched prescale puts the module clock out of band |

## Verification
The assertions take for granted that `scl_in` only reads low while either this block or another device pulls it low. They also take for granted that the divide and prescale inputs are changed only while `mod_en` is 0, so the counters never overrun a limit that shifts mid-phase. The stimulus holds the count inputs fixed during each enabled run. It alters `psc_val` mid-run only to show that the change is ignored. It keeps P at 2 or above whenever a high phase is timed, so the synchroniser latency fits inside one module-clock period. External stretching comes from a bench-side hold term that is ANDed into the modelled bus line.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Module clock out of band when src/div < lo or src/div > hi.
  function automatic logic rate_out_of_band(input longint unsigned src_hz,
                                            input longint unsigned lo_hz,
                                            input longint unsigned hi_hz,
                                            input longint unsigned div);
    return (src_hz < lo_hz * div) || (src_hz > hi_hz * div);
  endfunction

endpackage

// File: rtl/sclgen_prescaler.sv
module sclgen_prescaler
  import sclgen_pkg::*;
#(
  parameter int              PSC_W  = 8,
  parameter longint unsigned CLK_HZ = 64'd100_000_000,
  parameter longint unsigned MIN_HZ = 64'd6_700_000,
  parameter longint unsigned MAX_HZ = 64'd13_300_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_en,
  input  logic             run,
  input  logic [PSC_W-1:0] psc_val,
  output logic             mce,
  output logic             psc_bad
);

  logic [PSC_W-1:0] psc_lat, psc_lat_nxt;
  logic [PSC_W-1:0] pcnt, pcnt_nxt;
  logic             lat_en;
  logic             wrap;

  assign lat_en = ~mod_en;
  assign wrap   = (pcnt == psc_lat);
  assign mce    = run & wrap;

  always_comb begin
    psc_lat_nxt = psc_lat;
    if (lat_en) psc_lat_nxt = psc_val;
  end

  always_comb begin
    if (!mod_en || !run) pcnt_nxt = '0;
    else if (wrap)       pcnt_nxt = '0;
    else                 pcnt_nxt = pcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_lat <= '0;
      pcnt    <= '0;
    end else begin
      psc_lat <= psc_lat_nxt;
      pcnt    <= pcnt_nxt;
    end
  end

  always_comb begin
    psc_bad = rate_out_of_band(CLK_HZ, MIN_HZ, MAX_HZ,
                               longint'(psc_lat) + 64'd1);
  end

  // R3: captured prescale frozen after any cycle with the block running
  assert_psc_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mod_en) |-> $stable(psc_lat));

  // R2: divider count never passes the latched limit
  assert_pcnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= psc_lat);

endmodule

// File: rtl/sclgen_sync.sv
module sclgen_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr, sr_nxt;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sr_nxt = d;
    end else begin : g_many
      always_comb sr_nxt = {sr[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= sr_nxt;
  end

  assign q = sr[STAGES-1];

endmodule

// File: rtl/sclgen_phase.sv
module sclgen_phase
  import sclgen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_en,
  input  logic             mce,
  input  logic             scl_hi,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  output logic             scl_oe,
  output logic             tick,
  output logic             run
);

  localparam int CW = CNT_W + 1;

  phase_e        st, st_nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          tick_nxt;
  logic [CW-1:0] low_lim, high_lim;

  assign low_lim  = {1'b0, low_cnt}  + CW'(4);
  assign high_lim = {1'b0, high_cnt} + CW'(4);

  always_comb begin
    st_nxt   = st;
    cnt_nxt  = cnt;
    tick_nxt = 1'b0;
    if (!mod_en) begin
      st_nxt  = PH_OFF;
      cnt_nxt = '0;
    end else begin
      case (st)
        PH_OFF: begin
          st_nxt   = PH_LOW;
          cnt_nxt  = '0;
          tick_nxt = 1'b1;
        end
        PH_LOW: begin
          if (mce) begin
            if (cnt >= low_lim) begin
              st_nxt  = PH_HIGH;
              cnt_nxt = '0;
            end else begin
              cnt_nxt = cnt + 1'b1;
            end
          end
        end
        PH_HIGH: begin
          if (mce && scl_hi) begin
            if (cnt >= high_lim) begin
              st_nxt   = PH_LOW;
              cnt_nxt  = '0;
              tick_nxt = 1'b1;
            end else begin
              cnt_nxt = cnt + 1'b1;
            end
          end
        end
        default: begin
          st_nxt  = PH_OFF;
          cnt_nxt = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= PH_OFF;
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      st   <= st_nxt;
      cnt  <= cnt_nxt;
      tick <= tick_nxt;
    end
  end

  assign scl_oe = (st == PH_LOW);
  assign run    = (st != PH_OFF);

  // R6: a low bus line freezes the high-phase count
  assert_stretch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_HIGH && !scl_hi && mod_en) |=> (st == PH_HIGH && $stable(cnt)));

  // R8: disabling releases the line and clears the count
  assert_off_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> (st == PH_OFF && cnt == '0 && !tick));

  // R7: the tick never lasts two cycles
  assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/i2c_sclgen.sv
module i2c_sclgen
  import sclgen_pkg::*;
#(
  parameter int              PSC_W    = 8,
  parameter int              CNT_W    = 16,
  parameter int              SYNC_STG = 2,
  parameter longint unsigned CLK_HZ   = 64'd100_000_000,
  parameter longint unsigned MIN_HZ   = 64'd6_700_000,
  parameter longint unsigned MAX_HZ   = 64'd13_300_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_en,
  input  logic [PSC_W-1:0] psc_val,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic             scl_in,
  output logic             scl_oe,
  output logic             bit_tick,
  output logic             psc_bad
);

  logic [1:0] rst_sr;
  logic       rst_sn;
  logic       mce;
  logic       run;
  logic       scl_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= 2'b00;
    else        rst_sr <= {rst_sr[0], 1'b1};
  end
  assign rst_sn = rst_sr[1];

  sclgen_prescaler #(
    .PSC_W (PSC_W),
    .CLK_HZ(CLK_HZ),
    .MIN_HZ(MIN_HZ),
    .MAX_HZ(MAX_HZ)
  ) u_psc (
    .clk    (clk),
    .rst_n  (rst_sn),
    .mod_en (mod_en),
    .run    (run),
    .psc_val(psc_val),
    .mce    (mce),
    .psc_bad(psc_bad)
  );

  sclgen_sync #(
    .STAGES(SYNC_STG)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_sn),
    .d    (scl_in),
    .q    (scl_hi)
  );

  sclgen_phase #(
    .CNT_W(CNT_W)
  ) u_phase (
    .clk     (clk),
    .rst_n   (rst_sn),
    .mod_en  (mod_en),
    .mce     (mce),
    .scl_hi  (scl_hi),
    .low_cnt (low_cnt),
    .high_cnt(high_cnt),
    .scl_oe  (scl_oe),
    .tick    (bit_tick),
    .run     (run)
  );

  // R7: the tick only appears while the line is being pulled low
  assert_tick_pulls_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    bit_tick |-> scl_oe);

  // R1: nothing is pulled low while the internal reset holds
  assert_reset_release_R1: assert property (@(posedge clk)
    !rst_sn |-> (!scl_oe && !bit_tick));

endmodule

// File: tb/i2c_sclgen_bench.sv
`timescale 1ns/1ps
module i2c_sclgen_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mod_en;
  logic [7:0]  psc_val;
  logic [15:0] low_cnt, high_cnt;
  logic        ext_hold;
  logic        scl_in;
  logic        scl_oe, bit_tick, psc_bad;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  assign scl_in = ~(scl_oe | ext_hold);

  i2c_sclgen u_i2c_sclgen (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .psc_val(psc_val),
    .low_cnt(low_cnt), .high_cnt(high_cnt), .scl_in(scl_in),
    .scl_oe(scl_oe), .bit_tick(bit_tick), .psc_bad(psc_bad)
  );

  function automatic bit exp_bad(input int p);
    longint unsigned d = longint'(p) + 1;
    return (64'd100_000_000 < 64'd6_700_000 * d) ||
           (64'd100_000_000 > 64'd13_300_000 * d);
  endfunction

  function automatic int low_len(input int p, input int l);
    return (l + 5) * (p + 1);
  endfunction

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Starts at a negedge where scl_oe == lvl; counts edges until it changes.
  task automatic measure(input logic lvl, output int k);
    k = 0;
    do begin
      @(posedge clk); k++;
      @(negedge clk);
    end while (scl_oe == lvl && k < 100000);
  endtask

  task automatic start_run(input int p, input int l, input int h);
    @(negedge clk);
    mod_en = 1'b0; psc_val = 8'(p); low_cnt = 16'(l); high_cnt = 16'(h);
    @(negedge clk); @(negedge clk);
    chk("R5 flag", psc_bad == exp_bad(p), psc_bad, exp_bad(p));
    mod_en = 1'b1;
    @(negedge clk);
    chk("R8 first pull", scl_oe == 1'b1, scl_oe, 1);
    chk("R7 first tick", bit_tick == 1'b1, bit_tick, 1);
  endtask

  task automatic time_cycle(input int p, input int l, input int h);
    int k;
    measure(1'b1, k);
    chk("R2 low length", k == low_len(p, l), k, low_len(p, l));
    chk("R7 no tick in high", bit_tick == 1'b0, bit_tick, 0);
    measure(1'b0, k);
    chk("R4 high length", k == low_len(p, h), k, low_len(p, h));
    chk("R7 tick at pull", bit_tick == 1'b1, bit_tick, 1);
  endtask

  initial begin
    int k;
    int lo_b, hi_b;
    bit stayed;
    rst_n = 1'b0; mod_en = 1'b0; psc_val = 8'd9; low_cnt = 16'd3; high_cnt = 16'd7;
    ext_hold = 1'b0;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk("R1 reset oe", scl_oe == 1'b0, scl_oe, 0);
    chk("R1 reset tick", bit_tick == 1'b0, bit_tick, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after reset oe", scl_oe == 1'b0, scl_oe, 0);

    // Directed: P=9, L=3, H=7
    start_run(9, 3, 7);
    time_cycle(9, 3, 7);
    @(negedge clk);
    chk("R7 tick one cycle", bit_tick == 1'b0, bit_tick, 0);

    // R3: prescale change while running is ignored
    psc_val = 8'd3;
    measure(1'b1, k);
    measure(1'b0, k);
    chk("R3 high unchanged", k == low_len(9, 7), k, low_len(9, 7));
    chk("R3 flag unchanged", psc_bad == 1'b0, psc_bad, 0);
    measure(1'b1, k);
    chk("R3 low unchanged", k == low_len(9, 3), k, low_len(9, 3));

    // R8: disable mid high phase
    mod_en = 1'b0;
    @(negedge clk);
    chk("R8 released", scl_oe == 1'b0, scl_oe, 0);
    chk("R8 no tick", bit_tick == 1'b0, bit_tick, 0);
    @(negedge clk);
    chk("R3 new value after disable", psc_bad == 1'b1, psc_bad, 1);

    // R2/R4 at minimum counts and P=3
    start_run(3, 0, 0);
    time_cycle(3, 0, 0);

    // R6: stretching by another device
    start_run(7, 2, 4);
    ext_hold = 1'b1;
    measure(1'b1, k);
    chk("R6 low unaffected", k == low_len(7, 2), k, low_len(7, 2));
    stayed = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (scl_oe) stayed = 1'b0;
    end
    chk("R6 held while line low", stayed, stayed, 1);
    ext_hold = 1'b0;
    measure(1'b0, k);
    lo_b = (4 + 4) * 8 + 3;
    hi_b = (4 + 4) * 8 + 7 + 3;
    chk("R6 resume lower", k >= lo_b, k, lo_b);
    chk("R6 resume upper", k <= hi_b, k, hi_b);
    chk("R7 tick after stretch", bit_tick == 1'b1, bit_tick, 1);

    // R5: band edges
    for (int j = 0; j < 6; j++) begin
      int pv;
      case (j)
        0: pv = 0; 1: pv = 6; 2: pv = 7; 3: pv = 13; 4: pv = 14; default: pv = 255;
      endcase
      @(negedge clk);
      mod_en = 1'b0; psc_val = 8'(pv);
      @(negedge clk); @(negedge clk);
      chk("R5 band edge", psc_bad == exp_bad(pv), psc_bad, exp_bad(pv));
    end

    // Random runs
    for (int r = 0; r < 8; r++) begin
      int p, l, h;
      p = 2 + int'($urandom % 14);
      l = int'($urandom % 20);
      h = int'($urandom % 20);
      start_run(p, l, h);
      time_cycle(p, l, h);
    end

    mod_en = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule